// File: doc/BRIEF.md
# Reconfigurable FIFO-Partitioned Issue Queue

This block holds waiting instructions for an out-of-order core. It has a fixed pool of entries. The pool is divided into equal FIFOs, and only the oldest entry of each FIFO may ask for issue. Within one FIFO, instructions leave in the order they arrived. Across FIFOs, any ready head may go first, so the queue as a whole still issues out of order. Because only heads compete, the request and select logic works with one candidate per FIFO rather than one per entry.

The shape of the queue can change at run time, one step at a time. A merge step halves the number of FIFOs and doubles their depth. A split step does the reverse. The total entry count never changes, and entries are never moved when the shape changes. A change only redraws the FIFO boundaries over the entries, so a new shape applies from the next cycle without any lost cycles.

The steering choice (which FIFO an instruction goes to), the wakeup broadcast and the execution units are all outside the block. The block is used with one dispatch per cycle, one wakeup tag per cycle, and a grant of up to `ISSUE_W` heads per cycle. Every granted entry always leaves the queue at the next clock edge.

Top module: `split_fifo_iq`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, every entry is empty, `head_req` and `iss_valid` are zero, and `cfg_lg` equals `LG_RESET`.
- R2: With `cfg_lg` = L, FIFO f owns entries f·2^L up to f·2^L+2^L−1, and there are `ENTRIES`>>L FIFOs.
  - A dispatch writes the first free entry above the highest occupied entry of FIFO `disp_fifo`, or the FIFO's lowest entry if the FIFO is empty.
  - `disp_accept` is low, and nothing is written, when the top entry of that FIFO is occupied or when `disp_fifo` is at least the current FIFO count.
- R3: Bit e of `head_req` is high exactly when entry e is the lowest-index occupied entry of its FIFO and all its source-ready bits are set. A ready entry that is not a head raises no request.
- R4: An entry is granted only after every lower-index entry of its FIFO has left, so each FIFO issues in arrival order.
- R5: Up to `ISSUE_W` requesting heads are granted per cycle, lowest entry index first.
  - Slot 0 of `iss_valid`/`iss_tag` carries the lowest granted entry. Tag k is bits k·6 upward in `iss_tag`.
  - Granted entries leave at the next edge. Unused slots have `iss_valid` low.
- R6: A wakeup tag sets every matching source-ready bit in every occupied entry, whether or not that entry is a head. It also sets a matching source of a dispatch made in the same cycle. The effect is visible on `head_req` one cycle later.
- R7: `cfg_valid` with `cfg_split`=0 (merge) raises `cfg_lg` by one at the next edge, unless `cfg_lg` is `LG_MAX`, in which case the request is ignored. After a merge, former heads that are not the lowest occupied entry of the merged FIFO stop requesting.
- R8: `cfg_valid` with `cfg_split`=1 (split) lowers `cfg_lg` by one at the next edge, unless one of these holds, in which case the request is dropped and must be repeated:
  - `cfg_lg` is `LG_MIN`; or
  - some FIFO would hold occupied entries in both of its halves after this cycle's grants and dispatch.
- R9: Entries keep their position and contents across a shape change. An entry in a newly formed FIFO requests as soon as it is that FIFO's head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_fifo | input | $clog2(ENTRIES) | Target FIFO index under the current shape |
| disp_tag | input | TAG_W (6) | Instruction tag |
| disp_src_tag | input | NSRC·PTAG_W (14) | Source producer tags, source s at bits s·7 upward |
| disp_src_rdy | input | NSRC (2) | Source already available |
| disp_accept | output | 1 | Dispatch is written at this edge |
| wk_valid | input | 1 | Wakeup broadcast valid |
| wk_tag | input | PTAG_W (7) | Destination tag now available |
| cfg_valid | input | 1 | Shape change request |
| cfg_split | input | 1 | 1 = split (more, shallower FIFOs), 0 = merge |
| cfg_lg | output | $clog2(LG_MAX+1) | log2 of current FIFO depth |
| head_req | output | ENTRIES | Per-entry issue request (heads only) |
| iss_valid | output | ISSUE_W | Issue slot holds a grant |
| iss_tag | output | ISSUE_W·TAG_W | Tag of each granted instruction |

## Verification
The bench builds the queue with 16 entries, three issue slots, and shapes from sixteen FIFOs of depth 1 to two FIFOs of depth 8. The small pool makes full FIFOs, out-of-range FIFO indices and both ends of the shape range reachable in a few dispatches. With three issue slots, five simultaneous ready heads are enough to show the grant cap spilling into a second cycle. Merges are timed against pending wakeups to show a former head losing its request. A split is attempted while a FIFO straddles its halves to show the request being dropped and then taking effect once the FIFO drains.

// File: rtl/sfiq_pkg.sv
package sfiq_pkg;

    localparam int TAG_W  = 6;
    localparam int PTAG_W = 7;
    localparam int NSRC   = 2;

    typedef logic [NSRC-1:0][PTAG_W-1:0] src_tags_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        src_tags_t        src;
        logic [NSRC-1:0]  rdy;
    } iq_ent_t;

    typedef enum logic {
        SHAPE_MERGE = 1'b0,
        SHAPE_SPLIT = 1'b1
    } shape_op_e;

    // Which sources of an entry match a broadcast destination tag
    function automatic logic [NSRC-1:0] wake_hits(src_tags_t src, logic wv,
                                                  logic [PTAG_W-1:0] wt);
        logic [NSRC-1:0] h;
        for (int s = 0; s < NSRC; s++) begin
            h[s] = wv && (src[s] == wt);
        end
        return h;
    endfunction

    // FIFO number of an entry under a shape of depth 2**lg
    function automatic int fifo_of(int idx, int lg);
        return idx >> lg;
    endfunction

endpackage

// File: rtl/sfiq_region_view.sv
module sfiq_region_view #(
    parameter int ENTRIES = 64,
    parameter int LG_W    = 3,
    parameter int FIFO_W  = 6
) (
    input  logic [ENTRIES-1:0] valid_q,
    input  logic [ENTRIES-1:0] valid_nxt,
    input  logic [LG_W-1:0]    lg,
    input  logic               disp_valid,
    input  logic [FIFO_W-1:0]  disp_fifo,
    output logic [ENTRIES-1:0] head,
    output logic [ENTRIES-1:0] disp_sel,
    output logic               straddle
);
    import sfiq_pkg::*;

    always_comb begin
        int   sh;
        int   slot_mask;
        logic below;
        logic above;
        logic prev_ok;
        logic in_range;
        sh        = int'(lg);
        slot_mask = (1 << sh) - 1;
        in_range  = (ENTRIES >> sh) > int'(disp_fifo);
        head      = '0;
        disp_sel  = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            below = 1'b0;
            above = 1'b0;
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != e && fifo_of(j, sh) == fifo_of(e, sh) && valid_q[j]) begin
                    if (j < e) below = 1'b1;
                    else       above = 1'b1;
                end
            end
            head[e] = valid_q[e] & ~below;
            if ((e & slot_mask) == 0) prev_ok = 1'b1;
            else if (e > 0)           prev_ok = valid_q[e-1];
            else                      prev_ok = 1'b0;
            disp_sel[e] = disp_valid && in_range
                          && (fifo_of(e, sh) == int'(disp_fifo))
                          && !valid_q[e] && !above && prev_ok;
        end
    end

    // A split is unsafe while any FIFO spans both of its future halves
    always_comb begin
        int sh;
        sh       = int'(lg);
        straddle = 1'b0;
        if (sh > 0) begin
            for (int e = 0; e < ENTRIES; e++) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    if (valid_nxt[e] && valid_nxt[j]
                        && fifo_of(e, sh) == fifo_of(j, sh)
                        && ((e >> (sh - 1)) & 1) == 0
                        && ((j >> (sh - 1)) & 1) == 1) begin
                        straddle = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sfiq_entry_array.sv
module sfiq_entry_array
    import sfiq_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  iq_ent_t                        disp_ent,
    input  logic [ENTRIES-1:0]             disp_sel,
    input  logic [ENTRIES-1:0]             grant,
    input  logic                           wk_valid,
    input  logic [PTAG_W-1:0]              wk_tag,
    output logic [ENTRIES-1:0]             valid_q,
    output logic [ENTRIES-1:0]             valid_nxt,
    output logic [ENTRIES-1:0]             rdy_all,
    output logic [ENTRIES-1:0][TAG_W-1:0]  tags
);
    iq_ent_t ent_q [ENTRIES];

    assign valid_nxt = (valid_q & ~grant) | disp_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                ent_q[e] <= '0;
            end
        end else begin
            valid_q <= valid_nxt;
            for (int e = 0; e < ENTRIES; e++) begin
                if (disp_sel[e]) begin
                    ent_q[e].tag <= disp_ent.tag;
                    ent_q[e].src <= disp_ent.src;
                    ent_q[e].rdy <= disp_ent.rdy
                                    | wake_hits(disp_ent.src, wk_valid, wk_tag);
                end else if (valid_q[e]) begin
                    ent_q[e].rdy <= ent_q[e].rdy
                                    | wake_hits(ent_q[e].src, wk_valid, wk_tag);
                end
            end
        end
    end

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            rdy_all[e] = &ent_q[e].rdy;
            tags[e]    = ent_q[e].tag;
        end
    end

    // R2: a dispatch lands in exactly one free entry
    p_disp_free_r2: assert property (@(posedge clk) disable iff (rst)
        ((disp_sel & valid_q) == '0) && $onehot0(disp_sel));

    // R5: a granted entry is gone after the edge unless re-dispatched
    p_grant_leaves_r5: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |=> ((valid_q & $past(grant) & ~$past(disp_sel)) == '0));

endmodule

// File: rtl/sfiq_select.sv
module sfiq_select #(
    parameter int ENTRIES = 64,
    parameter int ISSUE_W = 6,
    parameter int IDX_W   = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ENTRIES-1:0]              req,
    output logic [ENTRIES-1:0]              grant,
    output logic [ISSUE_W-1:0]              slot_v,
    output logic [ISSUE_W-1:0][IDX_W-1:0]   slot_idx
);
    always_comb begin
        int cnt;
        cnt      = 0;
        grant    = '0;
        slot_v   = '0;
        slot_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (req[e] && cnt < ISSUE_W) begin
                grant[e]      = 1'b1;
                slot_v[cnt]   = 1'b1;
                slot_idx[cnt] = IDX_W'(e);
                cnt           = cnt + 1;
            end
        end
    end

    // R5: never more grants than issue slots
    p_grant_cap_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) <= ISSUE_W);

    // R3: only requesting heads are granted
    p_grant_subset_r3: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    // R5: when slots are left over, every request is served
    p_grant_all_r5: assert property (@(posedge clk) disable iff (rst)
        ($countones(req) <= ISSUE_W) |-> (grant == req));

endmodule

// File: rtl/sfiq_shape_ctrl.sv
module sfiq_shape_ctrl
    import sfiq_pkg::*;
#(
    parameter int LG_MIN   = 0,
    parameter int LG_MAX   = 6,
    parameter int LG_RESET = 0,
    parameter int LG_W     = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_valid,
    input  shape_op_e       cfg_op,
    input  logic            straddle,
    output logic [LG_W-1:0] lg_q
);
    logic do_merge;
    logic do_split;

    assign do_merge = cfg_valid && (cfg_op == SHAPE_MERGE) && (int'(lg_q) < LG_MAX);
    assign do_split = cfg_valid && (cfg_op == SHAPE_SPLIT) && (int'(lg_q) > LG_MIN)
                      && !straddle;

    always_ff @(posedge clk) begin
        if (rst)           lg_q <= LG_W'(LG_RESET);
        else if (do_merge) lg_q <= lg_q + LG_W'(1);
        else if (do_split) lg_q <= lg_q - LG_W'(1);
    end

    // R7, R8: the shape moves by at most one step per cycle
    p_one_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(lg_q) |-> ((int'(lg_q) == int'($past(lg_q)) + 1)
                           || (int'(lg_q) + 1 == int'($past(lg_q)))));

    // R8: the shape never leaves its legal range
    p_lg_range_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(lg_q) >= LG_MIN) && (int'(lg_q) <= LG_MAX));

    // R8: a straddling queue never splits
    p_no_unsafe_split_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_op == SHAPE_SPLIT && straddle) |=> $stable(lg_q));

endmodule

// File: rtl/split_fifo_iq.sv
module split_fifo_iq
    import sfiq_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int ISSUE_W  = 6,
    parameter int LG_MIN   = 0,
    parameter int LG_MAX   = 6,
    parameter int LG_RESET = 0,
    localparam int LG_W    = $clog2(LG_MAX + 1),
    localparam int FIFO_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      disp_valid,
    input  logic [FIFO_W-1:0]         disp_fifo,
    input  logic [TAG_W-1:0]          disp_tag,
    input  logic [NSRC*PTAG_W-1:0]    disp_src_tag,
    input  logic [NSRC-1:0]           disp_src_rdy,
    output logic                      disp_accept,
    input  logic                      wk_valid,
    input  logic [PTAG_W-1:0]         wk_tag,
    input  logic                      cfg_valid,
    input  logic                      cfg_split,
    output logic [LG_W-1:0]           cfg_lg,
    output logic [ENTRIES-1:0]        head_req,
    output logic [ISSUE_W-1:0]        iss_valid,
    output logic [ISSUE_W*TAG_W-1:0]  iss_tag
);
    iq_ent_t                          disp_ent;
    logic [ENTRIES-1:0]               valid_q;
    logic [ENTRIES-1:0]               valid_nxt;
    logic [ENTRIES-1:0]               rdy_all;
    logic [ENTRIES-1:0][TAG_W-1:0]    tags;
    logic [ENTRIES-1:0]               head;
    logic [ENTRIES-1:0]               disp_sel;
    logic [ENTRIES-1:0]               grant;
    logic                             straddle;
    logic [ISSUE_W-1:0]               slot_v;
    logic [ISSUE_W-1:0][FIFO_W-1:0]   slot_idx;
    shape_op_e                        cfg_op;

    always_comb begin
        disp_ent.tag = disp_tag;
        disp_ent.rdy = disp_src_rdy;
        for (int s = 0; s < NSRC; s++) begin
            disp_ent.src[s] = disp_src_tag[s*PTAG_W +: PTAG_W];
        end
    end

    assign cfg_op = cfg_split ? SHAPE_SPLIT : SHAPE_MERGE;

    sfiq_shape_ctrl #(
        .LG_MIN(LG_MIN), .LG_MAX(LG_MAX), .LG_RESET(LG_RESET), .LG_W(LG_W)
    ) u_shape (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
        .straddle(straddle), .lg_q(cfg_lg)
    );

    sfiq_region_view #(
        .ENTRIES(ENTRIES), .LG_W(LG_W), .FIFO_W(FIFO_W)
    ) u_view (
        .valid_q(valid_q), .valid_nxt(valid_nxt), .lg(cfg_lg),
        .disp_valid(disp_valid), .disp_fifo(disp_fifo),
        .head(head), .disp_sel(disp_sel), .straddle(straddle)
    );

    sfiq_entry_array #(
        .ENTRIES(ENTRIES)
    ) u_array (
        .clk(clk), .rst(rst), .disp_ent(disp_ent), .disp_sel(disp_sel),
        .grant(grant), .wk_valid(wk_valid), .wk_tag(wk_tag),
        .valid_q(valid_q), .valid_nxt(valid_nxt), .rdy_all(rdy_all), .tags(tags)
    );

    assign head_req    = head & rdy_all;
    assign disp_accept = |disp_sel;

    sfiq_select #(
        .ENTRIES(ENTRIES), .ISSUE_W(ISSUE_W), .IDX_W(FIFO_W)
    ) u_sel (
        .clk(clk), .rst(rst), .req(head_req), .grant(grant),
        .slot_v(slot_v), .slot_idx(slot_idx)
    );

    generate
        for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
            assign iss_valid[k]               = slot_v[k];
            assign iss_tag[k*TAG_W +: TAG_W]  = slot_v[k] ? tags[slot_idx[k]] : '0;
        end
    endgenerate

    // R3: a head is always an occupied entry
    p_head_valid_r3: assert property (@(posedge clk) disable iff (rst)
        (head & ~valid_q) == '0);

    // R4: grants come only from FIFO heads
    p_issue_head_r4: assert property (@(posedge clk) disable iff (rst)
        (grant & ~head) == '0);

    // R2: accepted dispatch leaves the target occupied
    p_accept_fills_r2: assert property (@(posedge clk) disable iff (rst)
        disp_accept |=> ((valid_q & $past(disp_sel)) == $past(disp_sel)));

endmodule

// File: tb/test_split_fifo_iq.sv
`timescale 1ns/1ps
module test_split_fifo_iq;
    import sfiq_pkg::*;

    localparam int N     = 16;
    localparam int IW    = 3;
    localparam int LGMAX = 3;
    localparam int LGW   = $clog2(LGMAX + 1);
    localparam int FW    = $clog2(N);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  disp_valid = 1'b0;
    logic [FW-1:0]         disp_fifo = '0;
    logic [TAG_W-1:0]      disp_tag = '0;
    logic [NSRC*PTAG_W-1:0] disp_src_tag = '0;
    logic [NSRC-1:0]       disp_src_rdy = '0;
    logic                  disp_accept;
    logic                  wk_valid = 1'b0;
    logic [PTAG_W-1:0]     wk_tag = '0;
    logic                  cfg_valid = 1'b0;
    logic                  cfg_split = 1'b0;
    logic [LGW-1:0]        cfg_lg;
    logic [N-1:0]          head_req;
    logic [IW-1:0]         iss_valid;
    logic [IW*TAG_W-1:0]   iss_tag;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    split_fifo_iq #(
        .ENTRIES(N), .ISSUE_W(IW), .LG_MIN(0), .LG_MAX(LGMAX), .LG_RESET(0)
    ) i_split_fifo_iq (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_fifo(disp_fifo),
        .disp_tag(disp_tag), .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
        .disp_accept(disp_accept), .wk_valid(wk_valid), .wk_tag(wk_tag),
        .cfg_valid(cfg_valid), .cfg_split(cfg_split), .cfg_lg(cfg_lg),
        .head_req(head_req), .iss_valid(iss_valid), .iss_tag(iss_tag)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] slot_tag(int k);
        return 32'(iss_tag[k*TAG_W +: TAG_W]);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        disp_valid = 1'b0;
        wk_valid   = 1'b0;
        cfg_valid  = 1'b0;
    endtask

    task automatic put(int f, int tag, int s0, bit r0, int s1, bit r1);
        disp_valid   = 1'b1;
        disp_fifo    = FW'(f);
        disp_tag     = TAG_W'(tag);
        disp_src_tag = {PTAG_W'(s1), PTAG_W'(s0)};
        disp_src_rdy = {r1, r0};
    endtask

    task automatic wake(int t);
        wk_valid = 1'b1;
        wk_tag   = PTAG_W'(t);
    endtask

    task automatic shape(bit split);
        cfg_valid = 1'b1;
        cfg_split = split;
    endtask

    task automatic t_reset();
        chk("R1", "head_req", 32'(head_req), 0);
        chk("R1", "iss_valid", 32'(iss_valid), 0);
        chk("R1", "cfg_lg", 32'(cfg_lg), 0);
    endtask

    task automatic t_single();
        put(5, 33, 1, 1, 2, 1);
        #1 chk("R2", "accept free fifo", 32'(disp_accept), 1);
        step();
        chk("R3", "ready head req", 32'(head_req), 32'h0020);
        chk("R5", "slot0 valid", 32'(iss_valid), 3'b001);
        chk("R5", "slot0 tag", slot_tag(0), 33);
        step();
        chk("R5", "granted entry left", 32'(head_req), 0);
    endtask

    task automatic t_grant_cap();
        int fl [5] = '{1, 3, 4, 7, 9};
        foreach (fl[i]) begin
            put(fl[i], 10 + fl[i], 10, 0, 0, 1);
            step();
        end
        chk("R3", "pending heads silent", 32'(head_req), 0);
        wake(10);
        step();
        chk("R6", "all heads woken", 32'(head_req), 32'h029A);
        chk("R5", "cap three slots", 32'(iss_valid), 3'b111);
        chk("R5", "slot0 lowest", slot_tag(0), 11);
        chk("R5", "slot1", slot_tag(1), 13);
        chk("R5", "slot2", slot_tag(2), 14);
        step();
        chk("R5", "leftover slots", 32'(iss_valid), 3'b011);
        chk("R5", "leftover slot0", slot_tag(0), 17);
        chk("R5", "leftover slot1", slot_tag(1), 19);
        step();
        chk("R5", "drained", 32'(iss_valid), 0);
    endtask

    task automatic t_in_order();
        shape(1'b0);
        step();
        chk("R7", "merge to depth 2", 32'(cfg_lg), 1);
        put(2, 40, 20, 0, 0, 1);
        step();
        put(2, 41, 21, 0, 0, 1);
        step();
        put(2, 42, 0, 1, 0, 1);
        #1 chk("R2", "full fifo refused", 32'(disp_accept), 0);
        disp_valid = 1'b0;
        wake(21);
        step();
        chk("R3", "woken non-head silent", 32'(head_req), 0);
        wake(20);
        step();
        chk("R4", "older entry first", 32'(head_req), 32'h0010);
        chk("R4", "older tag", slot_tag(0), 40);
        step();
        chk("R6", "non-head kept wakeup", 32'(head_req), 32'h0020);
        chk("R4", "younger tag", slot_tag(0), 41);
        step();
        chk("R4", "fifo empty", 32'(head_req), 0);
    endtask

    task automatic t_merge_hide();
        put(0, 50, 30, 0, 0, 1);
        step();
        put(1, 51, 30, 0, 0, 1);
        step();
        wake(30);
        shape(1'b0);
        step();
        chk("R7", "merge to depth 4", 32'(cfg_lg), 2);
        chk("R7", "former head hidden", 32'(head_req), 32'h0001);
        chk("R7", "merged head tag", slot_tag(0), 50);
        step();
        chk("R9", "kept entry now head", 32'(head_req), 32'h0004);
        chk("R9", "kept entry tag", slot_tag(0), 51);
        step();
    endtask

    task automatic t_split_defer();
        put(0, 60, 40, 0, 0, 1);
        step();
        put(0, 61, 40, 0, 0, 1);
        step();
        put(0, 62, 41, 0, 0, 1);
        step();
        shape(1'b1);
        step();
        chk("R8", "straddling split dropped", 32'(cfg_lg), 2);
        put(5, 63, 0, 1, 0, 1);
        #1 chk("R2", "out of range fifo", 32'(disp_accept), 0);
        disp_valid = 1'b0;
        wake(40);
        step();
        chk("R4", "first of three", slot_tag(0), 60);
        step();
        chk("R4", "second of three", slot_tag(0), 61);
        step();
        chk("R3", "pending head silent", 32'(head_req), 0);
        shape(1'b1);
        step();
        chk("R8", "clean split taken", 32'(cfg_lg), 1);
        wake(41);
        step();
        chk("R9", "split head requests", 32'(head_req), 32'h0004);
        chk("R9", "split head tag", slot_tag(0), 62);
        step();
    endtask

    task automatic t_limits();
        shape(1'b1);
        step();
        chk("R8", "split to depth 1", 32'(cfg_lg), 0);
        shape(1'b1);
        step();
        chk("R8", "split at minimum ignored", 32'(cfg_lg), 0);
        for (int i = 0; i < 3; i++) begin
            shape(1'b0);
            step();
        end
        chk("R7", "merged to maximum", 32'(cfg_lg), 3);
        shape(1'b0);
        step();
        chk("R7", "merge at maximum ignored", 32'(cfg_lg), 3);
    endtask

    task automatic t_same_cycle_wake();
        put(1, 7, 50, 0, 0, 1);
        wake(50);
        step();
        chk("R6", "dispatch caught wakeup", 32'(head_req), 32'h0100);
        chk("R6", "tag", slot_tag(0), 7);
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_grant_cap();
        t_in_order();
        t_merge_hide();
        t_split_defer();
        t_limits();
        t_same_cycle_wake();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule